// File: doc/BRIEF.md
# Interrupt Pin Level Tracker and Message Dispatcher

This block follows the state of a set of interrupt input pins (32 by default) and turns their activity into interrupt messages. Each pin is driven by commands rather than by a wire: a source may raise it, lower it or pulse it. Several sources may hold the same pin at once, so each pin keeps a saturating count of outstanding raises instead of a single level bit. Only the step of the count from zero to one requests a delivery.

The routing data for every pin comes from a redirection table that sits outside the block and is presented on a flat bus, 64 bits per pin. When a request is granted, the block reads the pin's entry, drops the request if the pin is masked or if a level-triggered pin is still waiting for its end-of-interrupt, and otherwise loads a message register that is handed off over a valid/ready port. For level-triggered pins the block asks the table to set that pin's remote-IRR bit. An end-of-interrupt input carrying a vector starts a scan over all pins. The scan asks the table to clear remote-IRR on every pin whose vector matches, and re-requests delivery for any of those pins whose count is still above zero.

Misuse is reported through one-cycle error pulses: a raise on a full count, a lower on an empty count, and a command on a pin index beyond the table. Running counters record delivered messages and both kinds of saturation.

Top module: `pin_dispatch`

## Requirements
- R1: A raise command (`cmdOp` = 2'b01) adds one to the pin's count. A delivery request is made only when the count goes from 0 to 1, and a raise on a pin whose count is already above zero produces no message.
- R2: A lower command (`cmdOp` = 2'b10) subtracts one from the pin's count. Going from 1 to 0 produces no message. A lower on a zero count leaves it at zero, pulses `errUnderflow` high for the one cycle after the command edge, and adds one to `statUnderflow`.
- R3: A raise on a count at its maximum (2^CNT_W−1) leaves it unchanged, pulses `errOverflow` for one cycle after the command edge, and adds one to `statOverflow`.
- R4: A pulse command (`cmdOp` = 2'b11) behaves as a raise followed by a lower in the same cycle. On a zero count it requests one delivery and leaves the count at zero. On a full count only the overflow of the raise takes effect and the lower is skipped.
- R5: A command whose `cmdPin` is at least NUM_PINS pulses `errBadPin` for one cycle and changes no count and no request.
- R6: A granted request for a pin whose mask bit (entry bit 16) is set is dropped without a message.
- R7: For a level-triggered pin (entry bit 15 = 1), a granted request is dropped when remote-IRR (entry bit 14) is set. Otherwise `irrSetVec` strobes that pin's bit for one cycle while the message is loaded. Edge-triggered pins never strobe `irrSetVec`.
- R8: A message carries the vector from entry bits 7:0, the delivery mode from bits 10:8, `msgPhysical` equal to the inverse of bit 11, the destination from bits 63:56, and `msgLevel` equal to bit 15.
- R9: `statDelivered` grows by one for every cycle in which `msgValid` and `msgReady` are both high.
- R10: An accepted end-of-interrupt holds `eoiBusy` high for NUM_PINS cycles while the pins are visited in ascending order, one per cycle. Every visited pin with remote-IRR set and a matching vector gets a one-cycle `irrClrVec` strobe, and is requested again if its count is nonzero. End-of-interrupt inputs that arrive while `eoiBusy` is high are ignored.
- R11: Among pending requests, the lowest pin index is granted first. A loaded message keeps `msgValid` high and its fields unchanged until `msgReady` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Pin command present this cycle |
| cmdOp | input | 2 | 01 raise, 10 lower, 11 pulse, 00 none |
| cmdPin | input | PIN_ID_W | Target pin index |
| redirEntries | input | NUM_PINS*64 | Redirection entries, pin i at bits i*64+63 : i*64 |
| eoiValid | input | 1 | End-of-interrupt present |
| eoiVector | input | 8 | Vector being retired |
| eoiBusy | output | 1 | End-of-interrupt scan in progress |
| msgValid | output | 1 | Message available |
| msgReady | input | 1 | Consumer accepts the message |
| msgVector | output | 8 | Message vector |
| msgDest | output | 8 | Destination identifier |
| msgDelMode | output | 3 | Delivery mode |
| msgPhysical | output | 1 | Destination is physical |
| msgLevel | output | 1 | Pin is level-triggered |
| irrSetVec | output | NUM_PINS | Per-pin request to set remote-IRR |
| irrClrVec | output | NUM_PINS | Per-pin request to clear remote-IRR |
| errOverflow | output | 1 | Raise on a full count |
| errUnderflow | output | 1 | Lower on an empty count |
| errBadPin | output | 1 | Pin index out of range |
| statDelivered | output | STAT_W | Messages accepted |
| statOverflow | output | STAT_W | Overflow events |
| statUnderflow | output | STAT_W | Underflow events |

## Verification
The bench builds the block with NUM_PINS = 8, a 4-bit pin index and a 4-bit count. With these values, every pin can be swept for message fields and edge behaviour. Every out-of-range index from 8 to 15 can be sent. A count can be driven to its ceiling of 15 and back in a few dozen commands, so both saturation paths and the pulse-at-ceiling case are checked exactly. The eight-pin end-of-interrupt scan is short enough to time to the cycle. The bench also models the table's remote-IRR bits from the set and clear strobes, so the level-trigger hold-off and the re-delivery on end-of-interrupt are observed as they would be in a real system.

// File: rtl/pin_dispatch_pkg.sv
package pin_dispatch_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_RAISE = 2'b01,
    OP_LOWER = 2'b10,
    OP_PULSE = 2'b11
  } pinOp_e;

  // Redirection entry field positions decoded by this block
  localparam int VEC_LSB      = 0;
  localparam int DELMODE_LSB  = 8;
  localparam int DESTMODE_BIT = 11;
  localparam int IRR_BIT      = 14;
  localparam int TRIG_BIT     = 15;
  localparam int MASK_BIT     = 16;
  localparam int DEST_LSB     = 56;
  localparam int ENTRY_W      = 64;

  typedef struct packed {
    logic   cmdHit;   // valid command on an in-range pin
    logic   cmdBad;   // command on an out-of-range pin
    pinOp_e cmdOp;
    logic   scanOn;   // EOI scan visits scanIdx this cycle
  } ctrlStrobe_t;

endpackage

// File: rtl/pin_dispatch_pick.sv
module pin_dispatch_pick #(
  parameter int N = 32,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     reqVec,
  output logic             anyReq,
  output logic [IDX_W-1:0] grantIdx
);
  always_comb begin
    anyReq   = |reqVec;
    grantIdx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (reqVec[i]) grantIdx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/pin_dispatch_ctrl.sv
module pin_dispatch_ctrl
  import pin_dispatch_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int PIN_ID_W = 8,
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  input  logic [1:0]          cmdOp,
  input  logic [PIN_ID_W-1:0] cmdPin,
  input  logic                eoiValid,
  input  logic [7:0]          eoiVector,
  output ctrlStrobe_t         strobe,
  output logic [IDX_W-1:0]    cmdIdx,
  output logic [IDX_W-1:0]    scanIdx,
  output logic [7:0]          scanVec,
  output logic                eoiBusy
);
  logic outOfRange;
  logic scanOn;

  assign outOfRange = ({1'b0, cmdPin} >= (PIN_ID_W + 1)'(NUM_PINS));
  assign cmdIdx     = cmdPin[IDX_W-1:0];

  always_comb begin
    strobe.cmdOp  = pinOp_e'(cmdOp);
    strobe.cmdBad = cmdValid && outOfRange;
    strobe.cmdHit = cmdValid && !outOfRange && (pinOp_e'(cmdOp) != OP_NONE);
    strobe.scanOn = scanOn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanOn  <= 1'b0;
      scanIdx <= '0;
      scanVec <= '0;
    end else if (!scanOn) begin
      if (eoiValid) begin
        scanOn  <= 1'b1;
        scanIdx <= '0;
        scanVec <= eoiVector;
      end
    end else if (scanIdx == IDX_W'(NUM_PINS - 1)) begin
      scanOn <= 1'b0;
    end else begin
      scanIdx <= scanIdx + 1'b1;
    end
  end

  assign eoiBusy = scanOn;
endmodule

// File: rtl/pin_dispatch_core.sv
module pin_dispatch_core
  import pin_dispatch_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int CNT_W    = 8,
  parameter int STAT_W   = 16,
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobe_t                 strobe,
  input  logic [IDX_W-1:0]            cmdIdx,
  input  logic [IDX_W-1:0]            scanIdx,
  input  logic [7:0]                  scanVec,
  input  logic [NUM_PINS*ENTRY_W-1:0] redirEntries,
  input  logic                        msgReady,
  output logic                        msgValid,
  output logic [7:0]                  msgVector,
  output logic [7:0]                  msgDest,
  output logic [2:0]                  msgDelMode,
  output logic                        msgPhysical,
  output logic                        msgLevel,
  output logic [NUM_PINS-1:0]         irrSetVec,
  output logic [NUM_PINS-1:0]         irrClrVec,
  output logic                        errOverflow,
  output logic                        errUnderflow,
  output logic                        errBadPin,
  output logic [STAT_W-1:0]           statDelivered,
  output logic [STAT_W-1:0]           statOverflow,
  output logic [STAT_W-1:0]           statUnderflow
);
  logic [NUM_PINS-1:0][ENTRY_W-1:0] entryTbl;
  logic [NUM_PINS-1:0][CNT_W-1:0]   pinCnt;
  logic [NUM_PINS-1:0]              pendVec, pendNext;
  logic [CNT_W-1:0] curCnt, cntNext;
  logic cntWe, riseHit, ovfHit, udfHit;
  logic [ENTRY_W-1:0] scanEntry, grantEntry;
  logic scanHit, refire;
  logic anyReq, slotFree, grantGo, grantDrop, grantLoad;
  logic [IDX_W-1:0] grantIdx;
  logic unusedEntryBits;

  assign entryTbl        = redirEntries;
  assign unusedEntryBits = ^entryTbl;

  // Saturating count update for the commanded pin
  always_comb begin
    curCnt  = pinCnt[cmdIdx];
    cntNext = curCnt;
    cntWe   = 1'b0;
    riseHit = 1'b0;
    ovfHit  = 1'b0;
    udfHit  = 1'b0;
    if (strobe.cmdHit) begin
      unique case (strobe.cmdOp)
        OP_RAISE: begin
          if (&curCnt) ovfHit = 1'b1;
          else begin
            cntNext = curCnt + 1'b1;
            cntWe   = 1'b1;
            riseHit = (curCnt == '0);
          end
        end
        OP_LOWER: begin
          if (curCnt == '0) udfHit = 1'b1;
          else begin
            cntNext = curCnt - 1'b1;
            cntWe   = 1'b1;
          end
        end
        OP_PULSE: begin
          if (&curCnt) ovfHit = 1'b1;
          else riseHit = (curCnt == '0);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinCnt <= '0;
    else if (cntWe) pinCnt[cmdIdx] <= cntNext;
  end

  // EOI scan: one pin per cycle
  assign scanEntry = entryTbl[scanIdx];
  assign scanHit   = strobe.scanOn && scanEntry[IRR_BIT] &&
                     (scanEntry[VEC_LSB +: 8] == scanVec);
  assign refire    = scanHit && (pinCnt[scanIdx] != '0);

  always_comb begin
    irrClrVec = '0;
    if (scanHit) irrClrVec[scanIdx] = 1'b1;
  end

  // Arbitration over pending requests
  pin_dispatch_pick #(.N(NUM_PINS)) pick_i (
    .reqVec  (pendVec),
    .anyReq  (anyReq),
    .grantIdx(grantIdx)
  );

  assign grantEntry = entryTbl[grantIdx];
  assign slotFree   = !msgValid || msgReady;
  assign grantGo    = anyReq && slotFree;
  assign grantDrop  = grantEntry[MASK_BIT] ||
                      (grantEntry[TRIG_BIT] && grantEntry[IRR_BIT]);
  assign grantLoad  = grantGo && !grantDrop;

  always_comb begin
    irrSetVec = '0;
    if (grantLoad && grantEntry[TRIG_BIT]) irrSetVec[grantIdx] = 1'b1;
  end

  always_comb begin
    pendNext = pendVec;
    if (grantGo) pendNext[grantIdx] = 1'b0;
    if (riseHit) pendNext[cmdIdx]   = 1'b1;
    if (refire)  pendNext[scanIdx]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendVec <= '0;
    else       pendVec <= pendNext;
  end

  // Message register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msgValid    <= 1'b0;
      msgVector   <= '0;
      msgDest     <= '0;
      msgDelMode  <= '0;
      msgPhysical <= 1'b0;
      msgLevel    <= 1'b0;
    end else if (grantLoad) begin
      msgValid    <= 1'b1;
      msgVector   <= grantEntry[VEC_LSB +: 8];
      msgDest     <= grantEntry[DEST_LSB +: 8];
      msgDelMode  <= grantEntry[DELMODE_LSB +: 3];
      msgPhysical <= ~grantEntry[DESTMODE_BIT];
      msgLevel    <= grantEntry[TRIG_BIT];
    end else if (msgReady) begin
      msgValid <= 1'b0;
    end
  end

  // Error pulses and statistics
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errOverflow   <= 1'b0;
      errUnderflow  <= 1'b0;
      errBadPin     <= 1'b0;
      statDelivered <= '0;
      statOverflow  <= '0;
      statUnderflow <= '0;
    end else begin
      errOverflow  <= ovfHit;
      errUnderflow <= udfHit;
      errBadPin    <= strobe.cmdBad;
      if (msgValid && msgReady) statDelivered <= statDelivered + 1'b1;
      if (ovfHit) statOverflow  <= statOverflow + 1'b1;
      if (udfHit) statUnderflow <= statUnderflow + 1'b1;
    end
  end
endmodule

// File: rtl/pin_dispatch.sv
module pin_dispatch
  import pin_dispatch_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int PIN_ID_W = 8,
  parameter int CNT_W    = 8,
  parameter int STAT_W   = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cmdValid,
  input  logic [1:0]                  cmdOp,
  input  logic [PIN_ID_W-1:0]         cmdPin,
  input  logic [NUM_PINS*ENTRY_W-1:0] redirEntries,
  input  logic                        eoiValid,
  input  logic [7:0]                  eoiVector,
  output logic                        eoiBusy,
  output logic                        msgValid,
  input  logic                        msgReady,
  output logic [7:0]                  msgVector,
  output logic [7:0]                  msgDest,
  output logic [2:0]                  msgDelMode,
  output logic                        msgPhysical,
  output logic                        msgLevel,
  output logic [NUM_PINS-1:0]         irrSetVec,
  output logic [NUM_PINS-1:0]         irrClrVec,
  output logic                        errOverflow,
  output logic                        errUnderflow,
  output logic                        errBadPin,
  output logic [STAT_W-1:0]           statDelivered,
  output logic [STAT_W-1:0]           statOverflow,
  output logic [STAT_W-1:0]           statUnderflow
);
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  ctrlStrobe_t      strobe;
  logic [IDX_W-1:0] cmdIdx, scanIdx;
  logic [7:0]       scanVec;

  pin_dispatch_ctrl #(.NUM_PINS(NUM_PINS), .PIN_ID_W(PIN_ID_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdPin(cmdPin),
    .eoiValid(eoiValid), .eoiVector(eoiVector),
    .strobe(strobe), .cmdIdx(cmdIdx), .scanIdx(scanIdx),
    .scanVec(scanVec), .eoiBusy(eoiBusy)
  );

  pin_dispatch_core #(.NUM_PINS(NUM_PINS), .CNT_W(CNT_W), .STAT_W(STAT_W)) core_i (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .cmdIdx(cmdIdx), .scanIdx(scanIdx), .scanVec(scanVec),
    .redirEntries(redirEntries), .msgReady(msgReady),
    .msgValid(msgValid), .msgVector(msgVector), .msgDest(msgDest),
    .msgDelMode(msgDelMode), .msgPhysical(msgPhysical), .msgLevel(msgLevel),
    .irrSetVec(irrSetVec), .irrClrVec(irrClrVec),
    .errOverflow(errOverflow), .errUnderflow(errUnderflow), .errBadPin(errBadPin),
    .statDelivered(statDelivered), .statOverflow(statOverflow),
    .statUnderflow(statUnderflow)
  );
endmodule

// File: rtl/pin_dispatch_chk.sv
module pin_dispatch_chk #(
  parameter int NUM_PINS = 32,
  parameter int PIN_ID_W = 8,
  parameter int STAT_W   = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                cmdValid,
  input logic [PIN_ID_W-1:0] cmdPin,
  input logic                eoiBusy,
  input logic                msgValid,
  input logic                msgReady,
  input logic [7:0]          msgVector,
  input logic [7:0]          msgDest,
  input logic [NUM_PINS-1:0] irrSetVec,
  input logic [NUM_PINS-1:0] irrClrVec,
  input logic                errOverflow,
  input logic                errUnderflow,
  input logic                errBadPin,
  input logic [STAT_W-1:0]   statDelivered
);
  // R11
  held_msg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgVector) && $stable(msgDest)));

  // R7
  irr_set_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irrSetVec));

  // R7
  irr_disjoint_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irrSetVec & irrClrVec) == '0);

  // R10
  irr_clr_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irrClrVec));

  // R10
  irr_clr_in_scan_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|irrClrVec) |-> eoiBusy);

  // R9
  deliver_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgReady) |=> (statDelivered == $past(statDelivered) + 1'b1));

  // R5
  bad_pin_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    errBadPin |-> ($past(cmdValid) && ({1'b0, $past(cmdPin)} >= (PIN_ID_W + 1)'(NUM_PINS))));

  // R2
  sat_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(errOverflow && errUnderflow));
endmodule

bind pin_dispatch pin_dispatch_chk #(
  .NUM_PINS(NUM_PINS), .PIN_ID_W(PIN_ID_W), .STAT_W(STAT_W)
) chk_i (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdPin(cmdPin),
  .eoiBusy(eoiBusy), .msgValid(msgValid), .msgReady(msgReady),
  .msgVector(msgVector), .msgDest(msgDest),
  .irrSetVec(irrSetVec), .irrClrVec(irrClrVec),
  .errOverflow(errOverflow), .errUnderflow(errUnderflow), .errBadPin(errBadPin),
  .statDelivered(statDelivered)
);

// File: tb/pin_dispatch_tb_top.sv
`timescale 1ns/100ps
module pin_dispatch_tb_top;
  localparam int NP  = 8;
  localparam int IDW = 4;
  localparam int CW  = 4;
  localparam int SW  = 16;
  localparam int MAXC = (1 << CW) - 1;
  localparam logic [1:0] RAISE = 2'b01, LOWER = 2'b10, PULSE = 2'b11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'b00;
  logic [IDW-1:0] cmdPin = '0;
  logic eoiValid = 1'b0;
  logic [7:0] eoiVector = '0;
  logic msgReady = 1'b1;
  logic [NP*64-1:0] redirBus;
  logic eoiBusy, msgValid, msgPhysical, msgLevel;
  logic [7:0] msgVector, msgDest;
  logic [2:0] msgDelMode;
  logic [NP-1:0] irrSetVec, irrClrVec;
  logic errOverflow, errUnderflow, errBadPin;
  logic [SW-1:0] statDelivered, statOverflow, statUnderflow;

  logic [63:0] cfg [NP];
  logic [NP-1:0] irrBits;

  pin_dispatch #(.NUM_PINS(NP), .PIN_ID_W(IDW), .CNT_W(CW), .STAT_W(SW)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdPin(cmdPin),
    .redirEntries(redirBus), .eoiValid(eoiValid), .eoiVector(eoiVector),
    .eoiBusy(eoiBusy), .msgValid(msgValid), .msgReady(msgReady),
    .msgVector(msgVector), .msgDest(msgDest), .msgDelMode(msgDelMode),
    .msgPhysical(msgPhysical), .msgLevel(msgLevel),
    .irrSetVec(irrSetVec), .irrClrVec(irrClrVec),
    .errOverflow(errOverflow), .errUnderflow(errUnderflow), .errBadPin(errBadPin),
    .statDelivered(statDelivered), .statOverflow(statOverflow),
    .statUnderflow(statUnderflow)
  );

  // Table model: configuration plus remote-IRR driven by the strobes
  always_comb begin
    for (int i = 0; i < NP; i++) begin
      redirBus[i*64 +: 64] = cfg[i];
      redirBus[i*64 + 14]  = irrBits[i];
    end
  end
  always @(posedge clk or negedge rstN) begin
    if (!rstN) irrBits <= '0;
    else irrBits <= (irrBits | irrSetVec) & ~irrClrVec;
  end

  // Accepted-message monitor
  int mCnt = 0;
  logic [7:0] mVec [64];
  logic [7:0] mDst [64];
  logic [2:0] mDm  [64];
  logic mPhy [64];
  logic mLvl [64];
  always @(negedge clk) begin
    if (rstN && msgValid && msgReady && mCnt < 64) begin
      mVec[mCnt] = msgVector; mDst[mCnt] = msgDest; mDm[mCnt] = msgDelMode;
      mPhy[mCnt] = msgPhysical; mLvl[mCnt] = msgLevel;
      mCnt = mCnt + 1;
    end
  end

  int checks = 0, errors = 0;
  int expOvf = 0, expUdf = 0;
  logic lastOvf, lastUdf, lastBad;
  int busyCycles;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mkEntry(input logic [7:0] dst, input logic msk,
      input logic lvl, input logic logical, input logic [2:0] dm, input logic [7:0] vec);
    logic [63:0] e = '0;
    e[63:56] = dst; e[16] = msk; e[15] = lvl; e[11] = logical; e[10:8] = dm; e[7:0] = vec;
    return e;
  endfunction

  task automatic cmd(input logic [1:0] op, input int pin);
    @(posedge clk); #1;
    cmdValid = 1'b1; cmdOp = op; cmdPin = IDW'(pin);
    @(posedge clk); #1;
    cmdValid = 1'b0; cmdOp = 2'b00;
    lastOvf = errOverflow; lastUdf = errUnderflow; lastBad = errBadPin;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic eoi(input logic [7:0] v);
    @(posedge clk); #1;
    eoiValid = 1'b1; eoiVector = v;
    @(posedge clk); #1;
    eoiValid = 1'b0;
    busyCycles = 0;
    while (eoiBusy && busyCycles < 100) begin
      @(posedge clk); #1;
      busyCycles++;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    logic anyFlag;
    for (int i = 0; i < NP; i++) cfg[i] = mkEntry(8'h00, 1'b1, 1'b0, 1'b0, 3'd0, 8'h00);
    idle(3);
    rstN = 1'b1;
    idle(1);

    // Reset state
    chk("R11", "reset msgValid", msgValid, 0);
    chk("R9", "reset statDelivered", statDelivered, 0);
    chk("R10", "reset eoiBusy", eoiBusy, 0);
    chk("R2", "reset err flags", {errOverflow, errUnderflow, errBadPin}, 0);

    // Per-pin sweep of fields, counting and 1->0 silence
    for (int p = 0; p < NP; p++) begin
      logic [2:0] pb = 3'(p);
      cfg[p] = mkEntry(8'hA0 + 8'(p), 1'b0, 1'b0, pb[0], pb, 8'h20 + 8'(p));
      base = mCnt;
      cmd(RAISE, p);
      chk("R5", "no bad flag on valid pin", lastBad, 0);
      idle(4);
      chk("R1", "raise 0->1 one message", mCnt - base, 1);
      chk("R8", "vector", mVec[base], 8'h20 + p);
      chk("R8", "destination", mDst[base], 8'hA0 + p);
      chk("R8", "delivery mode", mDm[base], pb);
      chk("R8", "physical flag", mPhy[base], !pb[0]);
      chk("R8", "level flag", mLvl[base], 0);
      chk("R7", "edge pin leaves IRR clear", irrBits[p], 0);
      cmd(RAISE, p);
      cmd(LOWER, p);
      anyFlag = lastUdf;
      cmd(LOWER, p);
      anyFlag = anyFlag | lastUdf;
      idle(4);
      chk("R1", "second raise and falls silent", mCnt - base, 1);
      chk("R2", "no underflow while count > 0", anyFlag, 0);
      cmd(LOWER, p);
      chk("R2", "underflow flag", lastUdf, 1);
      expUdf++;
    end
    chk("R9", "statDelivered after sweep", statDelivered, mCnt);

    // Saturation on pin 3
    base = mCnt;
    anyFlag = 1'b0;
    for (int k = 0; k < MAXC; k++) begin
      cmd(RAISE, 3);
      anyFlag = anyFlag | lastOvf;
    end
    chk("R3", "no overflow up to max", anyFlag, 0);
    cmd(RAISE, 3);
    chk("R3", "overflow flag", lastOvf, 1);
    expOvf++;
    cmd(PULSE, 3);
    chk("R4", "pulse at max overflows", lastOvf, 1);
    chk("R4", "pulse at max skips lower", lastUdf, 0);
    expOvf++;
    idle(4);
    chk("R3", "one message for whole climb", mCnt - base, 1);
    chk("R3", "statOverflow", statOverflow, expOvf);
    anyFlag = 1'b0;
    for (int k = 0; k < MAXC; k++) begin
      cmd(LOWER, 3);
      anyFlag = anyFlag | lastUdf;
    end
    chk("R3", "count held at max", anyFlag, 0);
    cmd(LOWER, 3);
    chk("R2", "underflow after descent", lastUdf, 1);
    expUdf++;

    // Pulse at zero on pin 5
    base = mCnt;
    cmd(PULSE, 5);
    chk("R4", "pulse at zero no error", {lastOvf, lastUdf}, 0);
    idle(4);
    chk("R4", "pulse at zero delivers", mCnt - base, 1);
    chk("R4", "pulse vector", mVec[base], 8'h25);
    cmd(LOWER, 5);
    chk("R4", "pulse returns count to zero", lastUdf, 1);
    expUdf++;

    // Out-of-range pins
    base = mCnt;
    for (int id = NP; id < (1 << IDW); id++) begin
      cmd(RAISE, id);
      chk("R5", "bad pin flag", lastBad, 1);
    end
    idle(4);
    chk("R5", "bad pins deliver nothing", mCnt - base, 0);
    anyFlag = 1'b1;
    for (int p = 0; p < NP; p++) begin
      cmd(LOWER, p);
      anyFlag = anyFlag & lastUdf;
      expUdf++;
    end
    chk("R5", "counts untouched by bad pins", anyFlag, 1);

    // Mask on pin 2
    cfg[2][16] = 1'b1;
    base = mCnt;
    cmd(RAISE, 2);
    idle(4);
    chk("R6", "masked pin silent", mCnt - base, 0);
    cfg[2][16] = 1'b0;
    cmd(LOWER, 2);
    cmd(RAISE, 2);
    idle(4);
    chk("R6", "unmasked pin delivers", mCnt - base, 1);

    // Level pin 4 with remote-IRR and EOI
    cfg[4] = mkEntry(8'h5A, 1'b0, 1'b1, 1'b0, 3'd1, 8'h44);
    base = mCnt;
    cmd(RAISE, 4);
    idle(4);
    chk("R7", "level message", mCnt - base, 1);
    chk("R8", "level flag set", mLvl[base], 1);
    chk("R7", "IRR set by strobe", irrBits[4], 1);
    cmd(LOWER, 4);
    cmd(RAISE, 4);
    idle(4);
    chk("R7", "IRR blocks delivery", mCnt - base, 1);
    eoi(8'h45);
    chk("R10", "scan length", busyCycles, NP);
    idle(4);
    chk("R10", "mismatched EOI keeps IRR", irrBits[4], 1);
    chk("R10", "mismatched EOI no message", mCnt - base, 1);
    eoi(8'h44);
    idle(4);
    chk("R10", "EOI re-fires asserted pin", mCnt - base, 2);
    chk("R10", "re-fire sets IRR again", irrBits[4], 1);
    cmd(LOWER, 4);
    eoi(8'h44);
    idle(4);
    chk("R10", "EOI on idle pin clears IRR", irrBits[4], 0);
    chk("R10", "EOI on idle pin no message", mCnt - base, 2);

    // EOI during a scan is ignored
    cmd(RAISE, 4);
    idle(4);
    cmd(LOWER, 4);
    @(posedge clk); #1;
    eoiValid = 1'b1; eoiVector = 8'h99;
    @(posedge clk); #1;
    eoiVector = 8'h44;
    @(posedge clk); #1;
    eoiValid = 1'b0;
    while (eoiBusy) begin @(posedge clk); #1; end
    idle(2);
    chk("R10", "EOI while busy ignored", irrBits[4], 1);
    eoi(8'h44);
    idle(2);
    chk("R10", "later EOI clears", irrBits[4], 0);

    // Priority and hold under back-pressure
    msgReady = 1'b0;
    base = mCnt;
    cmd(RAISE, 6);
    cmd(RAISE, 1);
    cmd(RAISE, 3);
    idle(2);
    chk("R11", "valid held", msgValid, 1);
    chk("R11", "first loaded vector", msgVector, 8'h26);
    idle(5);
    chk("R11", "still held and stable", {msgValid, msgVector}, {1'b1, 8'h26});
    msgReady = 1'b1;
    idle(8);
    chk("R11", "three delivered", mCnt - base, 3);
    chk("R11", "order first", mVec[base], 8'h26);
    chk("R11", "order lowest next", mVec[base+1], 8'h21);
    chk("R11", "order last", mVec[base+2], 8'h23);

    chk("R9", "statDelivered total", statDelivered, mCnt);
    chk("R2", "statUnderflow total", statUnderflow, expUdf);
    chk("R3", "statOverflow total", statOverflow, expOvf);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule